// File: doc/BRIEF.md
# NAND Flash Bus Strobe Controller

This block lets a processor drive a raw 8-bit NAND flash bus through a small set of memory-mapped words. Software controls the command-latch, address-latch and chip-enable pins directly through bits in a mode word. It moves one byte per access to the data word. Each data access produces exactly one write or read strobe on the flash pins. The strobe length and the data hold time that follows it are programmed in bus clocks.

The processor port is a request/ready handshake. Accesses to the control words complete in the cycle they are presented. A data access stalls the processor until the strobe and the hold phase have both finished. The flash ready/busy pin is synchronised and can be read as a status bit. A self-clearing reset bit returns all programmable state to zero.

Top module: `nand_strobe_ctrl`

## Requirements
- R1: After reset the mode word (0x04), timing word (0x14) and reset word (0x18) read 0. All nCE lines are high, CLE and ALE are low, nWE and nRE are high and the I/O bus is not driven.
- R2: The mode word at 0x04 reads back its low 8 bits as written. Bit 0 drives the CLE pin and bit 1 drives the ALE pin. Bits 6:5 hold an ECC mode field that drives no pin.
- R3: When mode bit 4 is set, only the nCE line selected by mode bits 3:2 is low. When bit 4 is clear, every nCE line is high. At most one nCE line is low at any time.
- R4: With mode bit 7 set, a write to the data word (0x00) puts bits 7:0 on the flash output bus with output enable high. It gives one nWE low pulse of exactly S+1 clocks, where S is timing bits 3:0. nRE stays high.
- R5: After the strobe ends, the access stalls for H+2 more clocks, where H is timing bits 7:4. Ready rises in the last of those clocks, and no second strobe follows.
- R6: With mode bit 7 clear, a read of the data word gives one nRE low pulse of S+1 clocks. It returns the flash input byte sampled in the last strobe clock, and nWE stays high.
- R7: Two data accesses in the wrong direction complete at once with no strobe and leave the flash output byte unchanged: a write with mode bit 7 clear, and a read with mode bit 7 set. Such a read returns 0.
- R8: The timing word at 0x14 reads back bits 7:0 as written. Bits 31:8 of the write are ignored.
- R9: Status word 0x08 bit 7 reads 1 while the ready/busy input is low, after a two-flop synchroniser. It reads 0 while that input is high.
- R10: Writing 1 to bit 0 of 0x18 makes that bit read 1 for RST_CYCLES clocks, after which it clears by itself. The mode and timing words are then 0.
- R11: Offsets 0x0C and 0x10 read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Access request, held until ready |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the word |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid with ready |
| bus_ready | output | 1 | Access completes on this clock |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_nce | output | NUM_CS | Active-low chip enables |
| nand_nwe | output | 1 | Active-low write strobe |
| nand_nre | output | 1 | Active-low read strobe |
| nand_io_out | output | 8 | Byte driven to the flash |
| nand_io_oe | output | 1 | Output enable for the I/O bus |
| nand_io_in | input | 8 | Byte from the flash |
| nand_rb_n | input | 1 | Flash ready/busy, low = busy |

## Verification
A wrong sequencer count shows up on the first data access as a strobe or hold phase that is one or more clocks off. It can also show up as a ready that arrives too early or never. The bench measures both phases clock by clock at the pins. A wrong mode bit or chip-select decode shows up as a wrong nCE line on the same clock the mode word is written. A broken self-clearing reset shows up as a reset bit that stays 1 for the wrong number of clocks, or as mode and timing words that are not zero afterwards.

// File: rtl/nfc_pkg.sv
package nfc_pkg;

  // byte offsets of the words seen by the processor
  localparam int unsigned OFF_DATA  = 0;
  localparam int unsigned OFF_MODE  = 4;
  localparam int unsigned OFF_STAT  = 8;
  localparam int unsigned OFF_ISTAT = 12;
  localparam int unsigned OFF_IMASK = 16;
  localparam int unsigned OFF_TIME  = 20;
  localparam int unsigned OFF_RST   = 24;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_STROBE = 2'd1,
    SEQ_HOLD   = 2'd2
  } seq_st_e;

  // mode word, msb first: bit7 write dir, 6:5 ecc, 4 ce, 3:2 cs, 1 ale, 0 cle
  typedef struct packed {
    logic       wdir;
    logic [1:0] ecc;
    logic       ce;
    logic [1:0] cs;
    logic       ale;
    logic       cle;
  } mode_t;

  typedef struct packed {
    logic [3:0] hold;
    logic [3:0] spw;
  } timing_t;

  // strobe low time in clocks for a programmed count
  function automatic logic [4:0] strobe_len(input logic [3:0] spw);
    return {1'b0, spw} + 5'd1;
  endfunction

  // hold time in clocks for a programmed count
  function automatic logic [4:0] hold_len(input logic [3:0] hold);
    return {1'b0, hold} + 5'd2;
  endfunction

endpackage

// File: rtl/nfc_regfile.sv
module nfc_regfile
  import nfc_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int ADDR_W      = 5,
  parameter int RST_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        wbyte,
  input  logic              nand_rb_n,
  output mode_t             mode,
  output timing_t           timing,
  output logic              soft_clr,
  output logic              ctrl_hit,
  output logic [BUS_W-1:0]  ctrl_rdata
);

  localparam int RCNT_W = $clog2(RST_CYCLES + 1);

  mode_t                  mode_q;
  timing_t                time_q;
  logic                   rst_busy;
  logic [RCNT_W-1:0]      rcnt;
  logic [SYNC_STAGES-1:0] rb_sync;
  logic                   flash_busy;

  logic hit_mode, hit_time, hit_rst, hit_stat;
  logic ctrl_wr;

  assign hit_mode = bus_addr == ADDR_W'(OFF_MODE);
  assign hit_time = bus_addr == ADDR_W'(OFF_TIME);
  assign hit_rst  = bus_addr == ADDR_W'(OFF_RST);
  assign hit_stat = bus_addr == ADDR_W'(OFF_STAT);
  assign ctrl_hit = bus_req && (bus_addr != ADDR_W'(OFF_DATA));
  assign ctrl_wr  = ctrl_hit && bus_wr;

  // programmable words, cleared while the soft reset runs
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      time_q <= '0;
    end else if (rst_busy) begin
      mode_q <= '0;
      time_q <= '0;
    end else if (ctrl_wr) begin
      if (hit_mode) mode_q <= mode_t'(wbyte);
      if (hit_time) time_q <= timing_t'(wbyte);
    end
  end

  // self-clearing soft reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_busy <= 1'b0;
      rcnt     <= '0;
    end else if (rst_busy) begin
      if (rcnt == '0) rst_busy <= 1'b0;
      else            rcnt     <= rcnt - 1'b1;
    end else if (ctrl_wr && hit_rst && wbyte[0]) begin
      rst_busy <= 1'b1;
      rcnt     <= RCNT_W'(RST_CYCLES - 1);
    end
  end

  // ready/busy synchroniser
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rb_sync <= '1;
        else        rb_sync <= nand_rb_n;
      end
    end else begin : g_syncn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rb_sync <= '1;
        else        rb_sync <= {rb_sync[SYNC_STAGES-2:0], nand_rb_n};
      end
    end
  endgenerate

  assign flash_busy = ~rb_sync[SYNC_STAGES-1];

  always_comb begin
    ctrl_rdata = '0;
    if (hit_mode) ctrl_rdata[7:0] = mode_q;
    if (hit_time) ctrl_rdata[7:0] = time_q;
    if (hit_stat) ctrl_rdata[7]   = flash_busy;
    if (hit_rst)  ctrl_rdata[0]   = rst_busy;
  end

  assign mode     = mode_q;
  assign timing   = time_q;
  assign soft_clr = rst_busy;

  // checker: length of the soft reset pulse
  logic [RCNT_W:0] chk_rlen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        chk_rlen <= '0;
    else if (rst_busy) chk_rlen <= chk_rlen + 1'b1;
    else               chk_rlen <= '0;
  end

  assert_rst_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |-> (chk_rlen < (RCNT_W+1)'(RST_CYCLES)));

  assert_rst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_busy |=> (mode_q == '0 && time_q == '0));

endmodule

// File: rtl/nfc_seq.sv
module nfc_seq
  import nfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_clr,
  input  logic       start_wr,
  input  logic       start_rd,
  input  timing_t    timing,
  input  logic [7:0] wbyte,
  input  logic [7:0] io_in,
  output logic       seq_idle,
  output logic       seq_done,
  output logic       nwe,
  output logic       nre,
  output logic [7:0] io_out,
  output logic       io_oe,
  output logic [7:0] rd_byte
);

  seq_st_e    st;
  logic [4:0] cnt;
  logic       is_wr;
  logic [7:0] io_q;
  logic [7:0] rd_q;
  logic       strobe_low;
  logic       strobe_last;
  logic       start;

  assign start = start_wr || start_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SEQ_IDLE;
      cnt   <= '0;
      is_wr <= 1'b0;
      io_q  <= '0;
      rd_q  <= '0;
    end else if (soft_clr) begin
      st    <= SEQ_IDLE;
      cnt   <= '0;
      is_wr <= 1'b0;
      io_q  <= '0;
      rd_q  <= '0;
    end else begin
      unique case (st)
        SEQ_IDLE: if (start) begin
          st    <= SEQ_STROBE;
          cnt   <= strobe_len(timing.spw) - 5'd1;
          is_wr <= start_wr;
          if (start_wr) io_q <= wbyte;
        end
        SEQ_STROBE: if (cnt == '0) begin
          st  <= SEQ_HOLD;
          cnt <= hold_len(timing.hold) - 5'd1;
          if (!is_wr) rd_q <= io_in;
        end else begin
          cnt <= cnt - 5'd1;
        end
        SEQ_HOLD: if (cnt == '0) st  <= SEQ_IDLE;
                  else           cnt <= cnt - 5'd1;
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  assign seq_idle    = st == SEQ_IDLE;
  assign strobe_low  = st == SEQ_STROBE;
  assign strobe_last = strobe_low && cnt == '0;
  assign seq_done    = st == SEQ_HOLD && cnt == '0;
  assign nwe         = !(strobe_low && is_wr);
  assign nre         = !(strobe_low && !is_wr);
  assign io_oe       = is_wr && !seq_idle;
  assign io_out      = io_q;
  assign rd_byte     = rd_q;

  // checker: measured strobe and hold lengths against the programmed counts
  logic [4:0] chk_low, chk_hold, chk_exp_s, chk_exp_h;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_low   <= '0;
      chk_hold  <= '0;
      chk_exp_s <= '0;
      chk_exp_h <= '0;
    end else begin
      chk_low  <= (!nwe || !nre) ? chk_low + 5'd1 : 5'd0;
      chk_hold <= (st == SEQ_HOLD) ? chk_hold + 5'd1 : 5'd0;
      if (seq_idle && start) begin
        chk_exp_s <= strobe_len(timing.spw);
        chk_exp_h <= hold_len(timing.hold);
      end
    end
  end

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nwe && !nre));

  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
    strobe_last |-> (5'(chk_low + 5'd1) == chk_exp_s));

  assert_hold_width_R5: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
    seq_done |-> (5'(chk_hold + 5'd1) == chk_exp_h));

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n || soft_clr)
    seq_done |=> (nwe && nre));

endmodule

// File: rtl/nfc_pin_drv.sv
module nfc_pin_drv
  import nfc_pkg::*;
#(
  parameter int NUM_CS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  mode_t             mode,
  output logic              cle,
  output logic              ale,
  output logic [NUM_CS-1:0] nce
);

  assign cle = mode.cle;
  assign ale = mode.ale;

  generate
    for (genvar i = 0; i < NUM_CS; i++) begin : g_nce
      assign nce[i] = !(mode.ce && mode.cs == 2'(i));
    end
  endgenerate

  assert_nce_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~nce));

  assert_nce_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mode.ce |-> (nce == '1));

endmodule

// File: rtl/nand_strobe_ctrl.sv
module nand_strobe_ctrl
  import nfc_pkg::*;
#(
  parameter int BUS_W       = 32,
  parameter int ADDR_W      = 5,
  parameter int NUM_CS      = 4,
  parameter int RST_CYCLES  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  output logic              bus_ready,
  output logic              nand_cle,
  output logic              nand_ale,
  output logic [NUM_CS-1:0] nand_nce,
  output logic              nand_nwe,
  output logic              nand_nre,
  output logic [7:0]        nand_io_out,
  output logic              nand_io_oe,
  input  logic [7:0]        nand_io_in,
  input  logic              nand_rb_n
);

  mode_t            mode;
  timing_t          timing;
  logic             soft_clr;
  logic             ctrl_hit;
  logic [BUS_W-1:0] ctrl_rdata;
  logic             seq_idle, seq_done;
  logic [7:0]       rd_byte;
  logic             data_req, dir_ok, ignored, start_wr, start_rd;
  logic             unused_hi;

  assign unused_hi = ^bus_wdata[BUS_W-1:8];

  assign data_req = bus_req && (bus_addr == ADDR_W'(OFF_DATA));
  assign dir_ok   = bus_wr == mode.wdir;
  assign ignored  = data_req && !dir_ok;
  assign start_wr = data_req && dir_ok && bus_wr && seq_idle;
  assign start_rd = data_req && dir_ok && !bus_wr && seq_idle;

  nfc_regfile #(
    .BUS_W(BUS_W), .ADDR_W(ADDR_W),
    .RST_CYCLES(RST_CYCLES), .SYNC_STAGES(SYNC_STAGES)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .wbyte(bus_wdata[7:0]), .nand_rb_n(nand_rb_n),
    .mode(mode), .timing(timing), .soft_clr(soft_clr),
    .ctrl_hit(ctrl_hit), .ctrl_rdata(ctrl_rdata)
  );

  nfc_seq u_seq (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_clr),
    .start_wr(start_wr), .start_rd(start_rd), .timing(timing),
    .wbyte(bus_wdata[7:0]), .io_in(nand_io_in),
    .seq_idle(seq_idle), .seq_done(seq_done),
    .nwe(nand_nwe), .nre(nand_nre),
    .io_out(nand_io_out), .io_oe(nand_io_oe), .rd_byte(rd_byte)
  );

  nfc_pin_drv #(.NUM_CS(NUM_CS)) u_pins (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .cle(nand_cle), .ale(nand_ale), .nce(nand_nce)
  );

  assign bus_ready = ctrl_hit || ignored || (data_req && seq_done);

  always_comb begin
    bus_rdata = '0;
    if (ctrl_hit) bus_rdata = ctrl_rdata;
    else if (data_req && !bus_wr && !mode.wdir && seq_done) bus_rdata[7:0] = rd_byte;
  end

  assert_ignored_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ignored |=> (nand_nwe && nand_nre));

endmodule

// File: tb/nand_strobe_ctrl_tb.sv
module nand_strobe_ctrl_tb;

  localparam int RST_CYCLES = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_req = 1'b0, bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready;
  logic        nand_cle, nand_ale, nand_nwe, nand_nre, nand_io_oe;
  logic [3:0]  nand_nce;
  logic [7:0]  nand_io_out;
  logic [7:0]  nand_io_in = '0;
  logic        nand_rb_n = 1'b1;

  int n_checks = 0;
  int n_fail   = 0;

  always #5 clk = ~clk;

  nand_strobe_ctrl #(.RST_CYCLES(RST_CYCLES)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_nce(nand_nce),
    .nand_nwe(nand_nwe), .nand_nre(nand_nre),
    .nand_io_out(nand_io_out), .nand_io_oe(nand_io_oe),
    .nand_io_in(nand_io_in), .nand_rb_n(nand_rb_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // one access; counts strobe samples and the total number of sampled clocks
  task automatic xfer(input bit wr, input logic [4:0] addr, input logic [31:0] wd,
                      output logic [31:0] rd, output int lo_we, output int lo_re,
                      output int total, output int oe_lo, output logic [7:0] io_seen);
    @(negedge clk);
    bus_req = 1'b1; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
    lo_we = 0; lo_re = 0; total = 0; oe_lo = 0; io_seen = '0;
    #1;
    forever begin
      total++;
      if (!nand_nwe) begin lo_we++; io_seen = nand_io_out; if (nand_io_oe) oe_lo++; end
      if (!nand_nre) lo_re++;
      if (bus_ready || total > 200) break;
      @(negedge clk); #1;
    end
    rd = bus_rdata;
    @(negedge clk);
    bus_req = 1'b0;
  endtask

  task automatic wr_reg(input logic [4:0] addr, input logic [31:0] d);
    logic [31:0] r; int a, b, c, e; logic [7:0] s;
    xfer(1'b1, addr, d, r, a, b, c, e, s);
  endtask

  task automatic rd_reg(input logic [4:0] addr, output logic [31:0] d);
    int a, b, c, e; logic [7:0] s;
    xfer(1'b0, addr, '0, d, a, b, c, e, s);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    rd_reg(5'h04, r); chk(r == 0, "R1 mode after reset", r, 0);
    rd_reg(5'h14, r); chk(r == 0, "R1 timing after reset", r, 0);
    rd_reg(5'h18, r); chk(r == 0, "R1 reset word after reset", r, 0);
    chk(nand_nce == 4'hF, "R1 nce idle", 32'(nand_nce), 32'hF);
    chk({nand_cle, nand_ale, nand_nwe, nand_nre, nand_io_oe} == 5'b00110,
        "R1 pin levels", 32'({nand_cle, nand_ale, nand_nwe, nand_nre, nand_io_oe}), 32'h6);
  endtask

  task automatic t_mode_pins();
    logic [31:0] r;
    wr_reg(5'h04, 32'h61); rd_reg(5'h04, r);
    chk(r == 32'h61, "R2 mode readback with ecc field", r, 32'h61);
    chk(nand_cle && !nand_ale, "R2 cle from bit0", 32'({nand_cle, nand_ale}), 32'h2);
    wr_reg(5'h04, 32'h02);
    chk(!nand_cle && nand_ale, "R2 ale from bit1", 32'({nand_cle, nand_ale}), 32'h1);
  endtask

  task automatic t_nce();
    for (int cs = 0; cs < 4; cs++) begin
      wr_reg(5'h04, 32'h10 | (cs << 2));
      chk(nand_nce == ~(4'b1 << cs), "R3 nce select", 32'(nand_nce), 32'(~(4'b1 << cs) & 4'hF));
    end
    wr_reg(5'h04, 32'h08);
    chk(nand_nce == 4'hF, "R3 ce clear keeps all high", 32'(nand_nce), 32'hF);
  endtask

  task automatic t_write(input logic [7:0] tim, input logic [31:0] d);
    logic [31:0] r; int lw, lr, tot, oe; logic [7:0] s;
    int spw = tim[3:0], hold = tim[7:4];
    wr_reg(5'h14, 32'(tim));
    wr_reg(5'h04, 32'h90);
    xfer(1'b1, 5'h00, d, r, lw, lr, tot, oe, s);
    chk(lw == spw + 1, "R4 nWE low width", 32'(lw), 32'(spw + 1));
    chk(lr == 0, "R4 nRE quiet on write", 32'(lr), 0);
    chk(s == d[7:0] && oe == lw, "R4 byte driven during strobe", 32'(s), 32'(d[7:0]));
    chk(tot - 1 - lw == hold + 2, "R5 hold length to ready", 32'(tot - 1 - lw), 32'(hold + 2));
    repeat (2) @(negedge clk);
    chk(nand_nwe && nand_nre, "R5 no second strobe", 32'({nand_nwe, nand_nre}), 32'h3);
  endtask

  task automatic t_read(input logic [7:0] tim, input logic [7:0] b);
    logic [31:0] r; int lw, lr, tot, oe; logic [7:0] s;
    int spw = tim[3:0], hold = tim[7:4];
    wr_reg(5'h14, 32'(tim));
    wr_reg(5'h04, 32'h10);
    nand_io_in = b;
    xfer(1'b0, 5'h00, '0, r, lw, lr, tot, oe, s);
    chk(r == 32'(b), "R6 read byte", r, 32'(b));
    chk(lr == spw + 1, "R6 nRE low width", 32'(lr), 32'(spw + 1));
    chk(lw == 0, "R6 nWE quiet on read", 32'(lw), 0);
    chk(tot - 1 - lr == hold + 2, "R5 hold length on read", 32'(tot - 1 - lr), 32'(hold + 2));
  endtask

  task automatic t_ignore(input logic [7:0] last_byte);
    logic [31:0] r; int lw, lr, tot, oe; logic [7:0] s;
    wr_reg(5'h04, 32'h10);
    xfer(1'b1, 5'h00, 32'h3C, r, lw, lr, tot, oe, s);
    chk(tot == 1 && lw == 0 && lr == 0, "R7 write with dir clear ignored", 32'(tot), 1);
    chk(nand_io_out == last_byte, "R7 output byte kept", 32'(nand_io_out), 32'(last_byte));
    wr_reg(5'h04, 32'h80);
    nand_io_in = 8'hEE;
    xfer(1'b0, 5'h00, '0, r, lw, lr, tot, oe, s);
    chk(tot == 1 && lr == 0 && lw == 0, "R7 read with dir set ignored", 32'(tot), 1);
    chk(r == 0, "R7 ignored read returns zero", r, 0);
  endtask

  task automatic t_timing();
    logic [31:0] r;
    wr_reg(5'h14, 32'hABCD_00F1); rd_reg(5'h14, r);
    chk(r == 32'hF1, "R8 timing readback", r, 32'hF1);
  endtask

  task automatic t_status();
    logic [31:0] r;
    @(negedge clk); nand_rb_n = 1'b0;
    repeat (3) @(negedge clk);
    rd_reg(5'h08, r); chk(r == 32'h80, "R9 busy flag set", r, 32'h80);
    nand_rb_n = 1'b1;
    repeat (3) @(negedge clk);
    rd_reg(5'h08, r); chk(r == 0, "R9 busy flag clear", r, 0);
  endtask

  task automatic t_unused();
    logic [31:0] r;
    wr_reg(5'h0C, 32'hFF); rd_reg(5'h0C, r); chk(r == 0, "R11 offset 0x0C", r, 0);
    wr_reg(5'h10, 32'hFF); rd_reg(5'h10, r); chk(r == 0, "R11 offset 0x10", r, 0);
  endtask

  task automatic t_soft_reset();
    logic [31:0] r; int ones = 0;
    wr_reg(5'h04, 32'h93);
    wr_reg(5'h14, 32'h44);
    wr_reg(5'h18, 32'h1);
    bus_req = 1'b1; bus_wr = 1'b0; bus_addr = 5'h18;
    for (int i = 0; i < 20; i++) begin
      #1;
      if (bus_rdata[0]) ones++;
      else break;
      @(negedge clk);
    end
    bus_req = 1'b0;
    chk(ones == RST_CYCLES, "R10 reset bit duration", 32'(ones), 32'(RST_CYCLES));
    rd_reg(5'h04, r); chk(r == 0, "R10 mode cleared", r, 0);
    rd_reg(5'h14, r); chk(r == 0, "R10 timing cleared", r, 0);
    chk(nand_nce == 4'hF && !nand_cle, "R10 pins idle after reset", 32'(nand_nce), 32'hF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mode_pins();
    t_nce();
    t_write(8'h32, 32'h0000_01A5);
    t_write(8'h1F, 32'h0000_005A);
    t_read(8'h32, 8'h5C);
    t_read(8'hF1, 8'hC3);
    t_ignore(8'h5A);
    t_timing();
    t_status();
    t_unused();
    t_soft_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule